// File: doc/BRIEF.md
# Sixteen-Pin General-Purpose I/O Port

This block is one general-purpose I/O port of sixteen pins behind a simple single-cycle register bus. Each pin has a four-bit configuration field. The field picks input (analog, floating or pulled) or output (push-pull or open-drain), and the output source (the port's own data register or a peripheral's alternate-function signal). The block turns each field into the pad controls: output value, output enable, pull-up, pull-down and alternate-function select.

Software changes the output data in one of three ways. It can write the whole data register. It can write a set/clear word that changes single bits without a read-modify-write. It can write a clear-only word. Pad levels come back through a two-flop synchronizer. Software can freeze any subset of pin configuration fields with a three-write key sequence on a lock register. The lock holds until reset.

Writes take effect at the clock edge on which `bus_wr` is high. Reads are combinational from `bus_addr`. Word addresses: 0 low config (pins 0-7), 1 high config (pins 8-15), 2 input data (read-only), 3 output data, 4 set/clear, 5 clear-only, 6 lock.

Top module: `pio_port`

## Requirements
- R1: After reset every configuration field reads 0x4 (floating input), so both config words read 0x4444_4444. The output data and lock registers read 0, and all pad control outputs are 0.
- R2: Pin p's field sits at bits [4*(p mod 8)+3 : 4*(p mod 8)] of config word 0 (p<8) or word 1 (p>=8). Bits [1:0] are the mode/speed code and bits [3:2] are the type code. A written field reads back unchanged, speed bits included.
- R3: With a nonzero mode code, type codes behave as follows. 00 drives `pad_out` from the data bit with `pad_oe`=1. 01 is open-drain on the data bit. 10 drives `pad_out` from `alt_in` with `pad_oe`=1. 11 is open-drain on `alt_in`. Open-drain means `pad_oe` equals the inverse of the source bit and `pad_out`=0. `alt_sel` is 1 exactly for type codes 10 and 11.
- R4: With mode code 00 the pin does not drive: `pad_out`, `pad_oe` and `alt_sel` are 0. Only type code 10 enables a pull. The pin's data bit chooses the direction: 1 gives `pull_up`, 0 gives `pull_dn`. `pull_up` and `pull_dn` are never both 1.
- R5: A write to word 4 sets data bit n for each 1 in bit n (n<16). It clears data bit n for each 1 in bit n+16. Set wins when both are 1. Zero bits leave data bits unchanged.
- R6: A write to word 5 clears data bit n for each 1 in bit n. All other data bits are unchanged.
- R7: Word 2 shows the pad levels after two clock edges of synchronization. Pins whose field is 0x0 (analog) read 0.
- R8: Three lock-word writes with the same pin mask in bits [15:0] complete the lock. The key bit 16 must be 1, then 0, then 1. Afterwards word 6 reads the key bit 1 together with the mask.
- R9: While locked, writes to config words leave the locked pins' fields unchanged. Unlocked fields in the same word and the output data register still accept writes.
- R10: A wrong mask, a wrong key value, or a write to any other word between steps restarts the sequence, and no lock takes effect. A step with key 1 counts as a new first step.
- R11: Once the key bit reads 1, further lock-word writes change neither the key bit nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | 16 | Pad input levels (asynchronous) |
| alt_in | input | 16 | Alternate-function output value per pin |
| pad_out | output | 16 | Pad output value |
| pad_oe | output | 16 | Pad output enable |
| pull_up | output | 16 | Pull-up enable |
| pull_dn | output | 16 | Pull-down enable |
| alt_sel | output | 16 | Alternate-function select |

## Verification
The assertions assume bus writes are whole-cycle strobes sampled at the rising edge. They stay quiet while the internal synchronized reset is still asserted. The bench never writes until two cycles after reset release and changes inputs only on the falling edge. The data-update properties take `bus_wdata` and `bus_addr` as stable across the edge, and the stimulus meets this by driving them with the strobe and holding them for the full cycle. `pad_in` is treated as asynchronous only by the synchronizer; the bench holds it steady for at least two edges before any read it checks.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int FIELD_W = 4;
  localparam int WORD_W  = 32;

  localparam logic [2:0] A_CFG_LO = 3'd0;
  localparam logic [2:0] A_CFG_HI = 3'd1;
  localparam logic [2:0] A_IN     = 3'd2;
  localparam logic [2:0] A_DATA   = 3'd3;
  localparam logic [2:0] A_SETCLR = 3'd4;
  localparam logic [2:0] A_CLR    = 3'd5;
  localparam logic [2:0] A_LOCK   = 3'd6;

  localparam int KEY_BIT = 16;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_ARM1 = 2'd1,
    LK_ARM0 = 2'd2
  } lk_state_e;
endpackage

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_async;
      stage2_q <= stage1_q;
    end
  end

  assign d_sync = stage2_q;
endmodule

// File: rtl/pio_lock_seq.sv
module pio_lock_seq
  import pio_pkg::*;
#(
  parameter int NPINS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_any,
  input  logic             wr_lock,
  input  logic             key_in,
  input  logic [NPINS-1:0] mask_in,
  output logic             lock_key,
  output logic [NPINS-1:0] lock_mask
);
  lk_state_e        st_q, st_d;
  logic [NPINS-1:0] pend_q, pend_d;
  logic             key_q, key_d;
  logic [NPINS-1:0] mask_q, mask_d;
  logic             upd_en;

  // frozen once the key has been set
  assign upd_en = wr_any && !key_q;

  always_comb begin
    st_d   = st_q;
    pend_d = pend_q;
    key_d  = key_q;
    mask_d = mask_q;
    if (!wr_lock) begin
      st_d = LK_IDLE;
    end else begin
      unique case (st_q)
        LK_ARM1: begin
          if (!key_in && mask_in == pend_q) st_d = LK_ARM0;
          else if (key_in) begin
            st_d   = LK_ARM1;
            pend_d = mask_in;
          end else st_d = LK_IDLE;
        end
        LK_ARM0: begin
          if (key_in && mask_in == pend_q) begin
            st_d   = LK_IDLE;
            key_d  = 1'b1;
            mask_d = mask_in;
          end else if (key_in) begin
            st_d   = LK_ARM1;
            pend_d = mask_in;
          end else st_d = LK_IDLE;
        end
        default: begin
          if (key_in) begin
            st_d   = LK_ARM1;
            pend_d = mask_in;
          end else st_d = LK_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LK_IDLE;
      pend_q <= '0;
      key_q  <= 1'b0;
      mask_q <= '0;
    end else if (upd_en) begin
      st_q   <= st_d;
      pend_q <= pend_d;
      key_q  <= key_d;
      mask_q <= mask_d;
    end
  end

  assign lock_key  = key_q;
  assign lock_mask = mask_q;
endmodule

// File: rtl/pio_pin_ctrl.sv
module pio_pin_ctrl
  import pio_pkg::*;
(
  input  logic [FIELD_W-1:0] cfg,
  input  logic               data_bit,
  input  logic               alt_bit,
  output logic               out,
  output logic               oe,
  output logic               pu,
  output logic               pd,
  output logic               sel,
  output logic               analog
);
  logic [1:0] mode;
  logic [1:0] kind;
  logic       src;

  assign mode = cfg[1:0];
  assign kind = cfg[3:2];

  always_comb begin
    out    = 1'b0;
    oe     = 1'b0;
    pu     = 1'b0;
    pd     = 1'b0;
    sel    = 1'b0;
    analog = 1'b0;
    src    = kind[1] ? alt_bit : data_bit;
    if (mode != 2'b00) begin
      sel = kind[1];
      if (kind[0]) begin
        oe  = ~src;
        out = 1'b0;
      end else begin
        oe  = 1'b1;
        out = src;
      end
    end else begin
      analog = (kind == 2'b00);
      if (kind == 2'b10) begin
        pu = data_bit;
        pd = ~data_bit;
      end
    end
  end
endmodule

// File: rtl/pio_port.sv
module pio_port
  import pio_pkg::*;
#(
  parameter int NPINS  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  pad_in,
  input  logic [NPINS-1:0]  alt_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pull_up,
  output logic [NPINS-1:0]  pull_dn,
  output logic [NPINS-1:0]  alt_sel
);
  localparam int HALF     = NPINS / 2;
  localparam int CFG_BITS = NPINS * FIELD_W;
  localparam int HALF_B   = HALF * FIELD_W;
  localparam logic [FIELD_W-1:0] CFG_RST = 4'h4;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic wr_lo, wr_hi, wr_data, wr_setclr, wr_clr, wr_lock;
  assign wr_lo     = bus_wr && (bus_addr == A_CFG_LO);
  assign wr_hi     = bus_wr && (bus_addr == A_CFG_HI);
  assign wr_data   = bus_wr && (bus_addr == A_DATA);
  assign wr_setclr = bus_wr && (bus_addr == A_SETCLR);
  assign wr_clr    = bus_wr && (bus_addr == A_CLR);
  assign wr_lock   = bus_wr && (bus_addr == A_LOCK);

  logic             lock_key;
  logic [NPINS-1:0] lock_mask;

  pio_lock_seq #(.NPINS(NPINS)) u_lock (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_any   (bus_wr),
    .wr_lock  (wr_lock),
    .key_in   (bus_wdata[KEY_BIT]),
    .mask_in  (bus_wdata[NPINS-1:0]),
    .lock_key (lock_key),
    .lock_mask(lock_mask)
  );

  // configuration fields
  logic [CFG_BITS-1:0] cfg_q, cfg_d;
  logic                cfg_en;
  assign cfg_en = wr_lo || wr_hi;

  always_comb begin
    cfg_d = cfg_q;
    for (int p = 0; p < NPINS; p++) begin
      if (!lock_mask[p]) begin
        if (p < HALF && wr_lo)
          cfg_d[p*FIELD_W +: FIELD_W] = bus_wdata[(p % HALF)*FIELD_W +: FIELD_W];
        if (p >= HALF && wr_hi)
          cfg_d[p*FIELD_W +: FIELD_W] = bus_wdata[(p % HALF)*FIELD_W +: FIELD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cfg_q <= {NPINS{CFG_RST}};
    else if (cfg_en) cfg_q <= cfg_d;
  end

  // output data register
  logic [NPINS-1:0] odr_q, odr_d;
  logic             odr_en;
  assign odr_en = wr_data || wr_setclr || wr_clr;

  always_comb begin
    odr_d = odr_q;
    if (wr_data)   odr_d = bus_wdata[NPINS-1:0];
    if (wr_setclr) odr_d = (odr_q & ~bus_wdata[16 +: NPINS]) | bus_wdata[NPINS-1:0];
    if (wr_clr)    odr_d = odr_q & ~bus_wdata[NPINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    odr_q <= '0;
    else if (odr_en) odr_q <= odr_d;
  end

  // input path
  logic [NPINS-1:0] in_sync;
  logic [NPINS-1:0] analog_m;

  pio_in_sync #(.W(NPINS)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .d_async(pad_in),
    .d_sync (in_sync)
  );

  // per-pin control decode
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    pio_pin_ctrl u_pin (
      .cfg     (cfg_q[g*FIELD_W +: FIELD_W]),
      .data_bit(odr_q[g]),
      .alt_bit (alt_in[g]),
      .out     (pad_out[g]),
      .oe      (pad_oe[g]),
      .pu      (pull_up[g]),
      .pd      (pull_dn[g]),
      .sel     (alt_sel[g]),
      .analog  (analog_m[g])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CFG_LO: bus_rdata = cfg_q[HALF_B-1:0];
      A_CFG_HI: bus_rdata = cfg_q[CFG_BITS-1:HALF_B];
      A_IN:     bus_rdata = {{(WORD_W-NPINS){1'b0}}, in_sync & ~analog_m};
      A_DATA:   bus_rdata = {{(WORD_W-NPINS){1'b0}}, odr_q};
      A_LOCK:   bus_rdata = {{(WORD_W-NPINS-1){1'b0}}, lock_key, lock_mask};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
  import pio_pkg::*;
#(
  parameter int NPINS = 16
) (
  input logic                       clk,
  input logic                       rst_ok,
  input logic                       bus_wr,
  input logic [2:0]                 bus_addr,
  input logic [31:0]                bus_wdata,
  input logic [NPINS-1:0]           odr_q,
  input logic [NPINS*FIELD_W-1:0]   cfg_q,
  input logic                       lock_key,
  input logic [NPINS-1:0]           lock_mask,
  input logic [NPINS-1:0]           pad_out,
  input logic [NPINS-1:0]           pad_oe,
  input logic [NPINS-1:0]           pull_up,
  input logic [NPINS-1:0]           pull_dn
);
  logic [NPINS*FIELD_W-1:0] lk_x;
  always_comb begin
    for (int p = 0; p < NPINS; p++) lk_x[p*FIELD_W +: FIELD_W] = {FIELD_W{lock_mask[p]}};
  end

  // R3: a pin only presents a high value while driving
  a_r3_no_float_high: assert property (@(posedge clk) disable iff (!rst_ok)
    (pad_out & ~pad_oe) == '0);

  // R4: pulls never fight
  a_r4_pull_exclusive: assert property (@(posedge clk) disable iff (!rst_ok)
    (pull_up & pull_dn) == '0);

  // R5: set/clear word effect on the data register
  a_r5_setclr_update: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && bus_addr == A_SETCLR) |=>
      odr_q == (($past(odr_q) & ~$past(bus_wdata[16 +: NPINS])) | $past(bus_wdata[NPINS-1:0])));

  // R6: clear-only word effect
  a_r6_clr_update: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && bus_addr == A_CLR) |=> odr_q == ($past(odr_q) & ~$past(bus_wdata[NPINS-1:0])));

  // R9: locked fields hold
  a_r9_locked_fields_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    lock_key |=> (cfg_q & lk_x) == ($past(cfg_q) & $past(lk_x)));

  // R11: key and mask frozen once set
  a_r11_key_sticky: assert property (@(posedge clk) disable iff (!rst_ok)
    lock_key |=> (lock_key && $stable(lock_mask)));
endmodule

bind pio_port pio_port_chk #(.NPINS(NPINS)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_q_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .odr_q    (odr_q),
  .cfg_q    (cfg_q),
  .lock_key (lock_key),
  .lock_mask(lock_mask),
  .pad_out  (pad_out),
  .pad_oe   (pad_oe),
  .pull_up  (pull_up),
  .pull_dn  (pull_dn)
);

// File: tb/sim_pio_port.sv
module sim_pio_port;
  localparam int PERIOD = 10;
  localparam logic [2:0] W_LO = 3'd0, W_HI = 3'd1, W_IN = 3'd2, W_DATA = 3'd3,
                         W_SC = 3'd4, W_CLR = 3'd5, W_LCK = 3'd6;

  logic        clk, rst_n, bus_wr;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] pad_in, alt_in, pad_out, pad_oe, pull_up, pull_dn, alt_sel;

  int checks, errors;

  pio_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .alt_in(alt_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_up(pull_up), .pull_dn(pull_dn),
    .alt_sel(alt_sel)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] xs(input logic [31:0] s);
    logic [31:0] x;
    x = s ^ (s << 13);
    x = x ^ (x >> 17);
    return x ^ (x << 5);
  endfunction

  // expected pin outputs for code c applied to all pins
  task automatic exp_pins(input logic [3:0] c, input logic [15:0] d, input logic [15:0] a,
                          output logic [15:0] eo, output logic [15:0] eoe,
                          output logic [15:0] eu, output logic [15:0] ed,
                          output logic [15:0] es);
    logic [15:0] src;
    src = c[3] ? a : d;
    eo = '0; eoe = '0; eu = '0; ed = '0; es = '0;
    if (c[1:0] != 2'b00) begin
      es = c[3] ? 16'hFFFF : 16'h0000;
      if (c[2]) begin eoe = ~src; eo = '0; end
      else      begin eoe = 16'hFFFF; eo = src; end
    end else if (c[3:2] == 2'b10) begin
      eu = d; ed = ~d;
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r, seed;
    logic [15:0] model, eo, eoe, eu, ed, es;
    checks = 0; errors = 0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0; alt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd(W_LO, r);   chk("R1 cfg lo", r, 32'h4444_4444);
    rd(W_HI, r);   chk("R1 cfg hi", r, 32'h4444_4444);
    rd(W_DATA, r); chk("R1 data", r, 32'h0);
    rd(W_LCK, r);  chk("R1 lock", r, 32'h0);
    chk("R1 pad controls", {pad_out, pad_oe}, 32'h0);
    chk("R1 pulls", {pull_up, pull_dn}, 32'h0);

    // R2 field placement: pin 6 and pin 9 push-pull, rest analog
    wr(W_LO, 32'h0100_0000);
    wr(W_HI, 32'h0000_0010);
    wr(W_DATA, 32'h0000_FFFF);
    chk("R2 layout oe", {16'h0, pad_oe}, 32'h0000_0240);
    chk("R2 layout out", {16'h0, pad_out}, 32'h0000_0240);

    // R2/R3/R4/R7 sweep every code over all pins, two data/alt patterns
    pad_in = 16'h9A6F;
    for (int c = 0; c < 16; c++) begin
      wr(W_LO, {8{c[3:0]}});
      wr(W_HI, {8{c[3:0]}});
      rd(W_LO, r); chk("R2 readback lo", r, {8{c[3:0]}});
      rd(W_HI, r); chk("R2 readback hi", r, {8{c[3:0]}});
      for (int k = 0; k < 2; k++) begin
        model  = (k == 0) ? 16'hA5C3 : 16'h5A3C;
        alt_in = (k == 0) ? 16'h3C5A : 16'hC3A5;
        wr(W_DATA, {16'h0, model});
        #1;
        exp_pins(c[3:0], model, alt_in, eo, eoe, eu, ed, es);
        chk("R3 out/oe", {pad_out, pad_oe}, {eo, eoe});
        chk("R4 pulls", {pull_up, pull_dn}, {eu, ed});
        chk("R3 alt select", {16'h0, alt_sel}, {16'h0, es});
      end
      rd(W_IN, r);
      chk("R7 input/analog", r, (c == 0) ? 32'h0 : {16'h0, pad_in});
    end

    // R7 synchronizer latency
    wr(W_LO, 32'h4444_4444);
    wr(W_HI, 32'h4444_4444);
    pad_in = 16'h0000;
    repeat (3) @(negedge clk);
    pad_in = 16'h1234;
    @(negedge clk);
    rd(W_IN, r); chk("R7 one edge still old", r, 32'h0);
    @(negedge clk);
    rd(W_IN, r); chk("R7 two edges new", r, 32'h0000_1234);

    // R5 set/clear priority and R6 clear-only
    wr(W_DATA, 32'h0);
    wr(W_SC, 32'h0001_0001);
    rd(W_DATA, r); chk("R5 set wins", r, 32'h0000_0001);
    wr(W_SC, 32'h0000_0000);
    rd(W_DATA, r); chk("R5 zero no effect", r, 32'h0000_0001);
    seed = 32'h1357_9BDF;
    model = 16'h0001;
    for (int i = 0; i < 40; i++) begin
      seed = xs(seed);
      if (seed[0]) begin
        wr(W_SC, seed);
        model = (model & ~seed[31:16]) | seed[15:0];
        rd(W_DATA, r); chk("R5 set/clear sweep", r, {16'h0, model});
      end else begin
        wr(W_CLR, seed);
        model = model & ~seed[15:0];
        rd(W_DATA, r); chk("R6 clear sweep", r, {16'h0, model});
      end
    end

    // R10 broken sequences
    wr(W_LCK, 32'h0001_00F0);
    wr(W_LCK, 32'h0000_00F0);
    wr(W_DATA, 32'h0000_0000);
    wr(W_LCK, 32'h0001_00F0);
    rd(W_LCK, r); chk("R10 other write breaks", r, 32'h0);
    wr(W_LCK, 32'h0000_00F1);
    wr(W_LCK, 32'h0001_00F0);
    rd(W_LCK, r); chk("R10 wrong mask breaks", r, 32'h0);
    wr(W_LCK, 32'h0001_00F0);
    wr(W_LCK, 32'h0001_00F0);
    rd(W_LCK, r); chk("R10 wrong key breaks", r, 32'h0);

    // R8 full sequence locks pins 4,5 (restarts first step)
    wr(W_LCK, 32'h0001_0030);
    wr(W_LCK, 32'h0000_0030);
    wr(W_LCK, 32'h0001_0030);
    rd(W_LCK, r); chk("R8 key and mask", r, 32'h0001_0030);

    // R9 locked fields hold, others and data writable
    wr(W_LO, 32'hFFFF_FFFF);
    rd(W_LO, r); chk("R9 lo partial", r, 32'hFF44_FFFF);
    wr(W_HI, 32'h1111_1111);
    rd(W_HI, r); chk("R9 hi open", r, 32'h1111_1111);
    wr(W_DATA, 32'h0000_BEEF);
    rd(W_DATA, r); chk("R9 data open", r, 32'h0000_BEEF);

    // R11 relock attempt ignored
    wr(W_LCK, 32'h0001_FFFF);
    wr(W_LCK, 32'h0000_FFFF);
    wr(W_LCK, 32'h0001_FFFF);
    rd(W_LCK, r); chk("R11 lock frozen", r, 32'h0001_0030);
    wr(W_LO, 32'h0000_0000);
    rd(W_LO, r); chk("R11 same pins still", r, 32'h0044_0000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule